// File: doc/BRIEF.md
# First-Order Delta-Sigma Modulator

This block is a cycle-level digital model of a first-order delta-sigma modulator loop. On every oversampling clock where the input is marked valid, it takes a signed multi-bit sample and returns one bit. Over a long run, the share of ones in that bit stream follows the input level. The block is meant to drive a downstream decimating filter, or to stand in for the analog front end of a converter in a larger simulation.

Inside the loop, a 1-bit DAC turns the bit from the previous valid sample into a feedback level of plus or minus full scale. A difference stage takes that level away from the new sample. An integrator adds the result to its running total. A zero-threshold comparator reads the sign of the updated total and registers it as the next output bit. Full scale is FS = 2^(W-1), so the input range is [-FS, FS-1]. The integrator has W+GUARD bits.

Top module: `sdm_mod1`

## Requirements
- R1: A synchronous reset sets `bit_out` to 0 and clears the integrator to 0. The first valid sample of 0 after reset therefore gives `bit_out` = 1.
- R2: The feedback level for a valid sample is +FS when `bit_out` (the previous bit) is 1 and -FS when it is 0, with FS = 2^(W-1).
- R3: On each valid sample the integrator becomes its old value plus (input minus feedback level). It always stays within [-2*FS, 2*FS-1], so it never overflows.
- R4: After the clock edge that accepts a valid sample, `bit_out` is 1 when the updated integrator is zero or positive, and 0 when it is negative.
- R5: While `in_vld` is 0, `bit_out` and the integrator keep their values, whatever `in_smp` carries.
- R6: For a constant input x held over N valid samples, the count of ones is within 2 of N*(x+FS)/(2*FS). Inputs of -FS/2, 0 and +FS/2 give densities of 0.25, 0.5 and 0.75.
- R7: The extreme inputs saturate without wrapping. With x = -FS held, the output shows at most one 1 and then stays 0. With x = FS-1 held, at most two zeros appear in 256 samples.
- R8: Asserting reset in the middle of a stream, even while `in_vld` is 1, restores the R1 state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks `in_smp` as a sample to convert this cycle |
| in_smp | input | W | Signed two's-complement input sample |
| bit_out | output | 1 | Modulator output bit, which is also the DAC select for the next sample |

## Verification
The bench runs every sample against its own model of the loop equations. A design that fed back the current bit instead of the previous one, or that used a half-scale DAC level, goes wrong within the first few samples. Full-scale inputs at both extremes target an integrator that is too narrow; such a design would wrap and produce bursts of the wrong polarity. Idle gaps with random data on `in_smp` catch a design that integrates while `in_vld` is low. A reset in the middle of a stream catches a reset that leaves the integrator holding a residue, because the next sample would then produce the wrong first bit.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic {
    DAC_NEG = 1'b0,
    DAC_POS = 1'b1
  } dac_sel_e;

  localparam int GUARD_BITS_DEFAULT = 2;
endpackage

// File: rtl/sdm_diff.sv
module sdm_diff #(
  parameter int W  = 8,
  parameter int AW = 10
) (
  input  logic signed [W-1:0]  in_smp,
  input  sdm_pkg::dac_sel_e    fb_sel,
  output logic signed [AW-1:0] fb_lvl,
  output logic signed [AW-1:0] diff
);
  localparam int FS = 1 << (W-1);

  function automatic logic signed [AW-1:0] dac_level(input sdm_pkg::dac_sel_e s);
    logic signed [AW-1:0] mag;
    mag = signed'(AW'(FS));
    return (s == sdm_pkg::DAC_POS) ? mag : -mag;
  endfunction

  function automatic logic signed [AW-1:0] widen(input logic signed [W-1:0] v);
    return signed'({{(AW-W){v[W-1]}}, v});
  endfunction

  always_comb begin
    fb_lvl = dac_level(fb_sel);
    diff   = widen(in_smp) - fb_lvl;
  end
endmodule

// File: rtl/sdm_integ.sv
module sdm_integ #(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [AW-1:0] diff,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] acc_nxt
);
  function automatic logic signed [AW-1:0] accumulate(
    input logic signed [AW-1:0] a, input logic signed [AW-1:0] d);
    return a + d;
  endfunction

  assign acc_nxt = accumulate(acc_q, diff);

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [AW-1:0] acc_nxt,
  output sdm_pkg::dac_sel_e    bit_q
);
  function automatic sdm_pkg::dac_sel_e compare_zero(input logic signed [AW-1:0] v);
    return (v >= 0) ? sdm_pkg::DAC_POS : sdm_pkg::DAC_NEG;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     bit_q <= sdm_pkg::DAC_NEG;
    else if (en) bit_q <= compare_zero(acc_nxt);
  end
endmodule

// File: rtl/sdm_mod1.sv
module sdm_mod1 #(
  parameter int W     = 8,
  parameter int GUARD = sdm_pkg::GUARD_BITS_DEFAULT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_smp,
  output logic                bit_out
);
  localparam int AW = W + GUARD;

  sdm_pkg::dac_sel_e    fb_sel;
  logic signed [AW-1:0] fb_lvl;
  logic signed [AW-1:0] diff;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nxt;
  logic                 step_en;

  assign step_en = in_vld;

  sdm_diff #(.W(W), .AW(AW)) u_diff (
    .in_smp (in_smp),
    .fb_sel (fb_sel),
    .fb_lvl (fb_lvl),
    .diff   (diff)
  );

  sdm_integ #(.AW(AW)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .en      (step_en),
    .diff    (diff),
    .acc_q   (acc_q),
    .acc_nxt (acc_nxt)
  );

  sdm_quant #(.AW(AW)) u_quant (
    .clk     (clk),
    .rst     (rst),
    .en      (step_en),
    .acc_nxt (acc_nxt),
    .bit_q   (fb_sel)
  );

  assign bit_out = (fb_sel == sdm_pkg::DAC_POS);
endmodule

// File: rtl/sdm_mod1_chk.sv
module sdm_mod1_chk #(
  parameter int W  = 8,
  parameter int AW = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_vld,
  input logic signed [W-1:0]  in_smp,
  input logic                 bit_out,
  input logic signed [AW-1:0] acc_q
);
  localparam int FS = 1 << (W-1);
  localparam logic signed [AW-1:0] ACC_MIN = -signed'(AW'(2*FS));
  localparam logic signed [AW-1:0] ACC_MAX = signed'(AW'(2*FS-1));
  localparam logic signed [AW-1:0] FS_AW   = signed'(AW'(FS));

  logic signed [AW-1:0] in_wide;
  assign in_wide = signed'({{(AW-W){in_smp[W-1]}}, in_smp});

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && bit_out == 1'b0));

  assert_feedback_step_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> acc_q == $past(acc_q) + $past(in_wide) - ($past(bit_out) ? FS_AW : -FS_AW));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= ACC_MIN) && (acc_q <= ACC_MAX));

  assert_sign_bit_R4: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> bit_out == (acc_q >= 0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(bit_out) && $stable(acc_q)));
endmodule

bind sdm_mod1 sdm_mod1_chk #(.W(W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_smp  (in_smp),
  .bit_out (bit_out),
  .acc_q   (acc_q)
);

// File: tb/sdm_mod1_tb.sv
`timescale 1ns/1ps
module sdm_mod1_tb;
  localparam int W  = 8;
  localparam int FS = 1 << (W-1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_vld = 1'b0;
  logic signed [W-1:0] in_smp = '0;
  logic                bit_out;

  int n_chk  = 0;
  int n_fail = 0;
  int m_acc  = 0;
  int m_bit  = 0;

  always #2.5 clk = ~clk;

  sdm_mod1 #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp), .bit_out(bit_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_vld = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_acc = 0; m_bit = 0;
  endtask

  // One valid sample; model follows the loop equations from the requirements.
  task automatic feed(input int x, input string req);
    int fb;
    @(negedge clk); in_vld = 1'b1; in_smp = W'(x);
    @(posedge clk); #1;
    in_vld = 1'b0;
    fb = (m_bit == 1) ? FS : -FS;
    m_acc = m_acc + x - fb;
    m_bit = (m_acc >= 0) ? 1 : 0;
    check(req, int'(bit_out), m_bit);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset bit", int'(bit_out), 0);
    feed(0, "R1 first sample after reset");
    check("R1 first bit is one", int'(bit_out), 1);
  endtask

  task automatic t_feedback();
    do_reset();
    // 0,0,0: acc 128 ->1, 0 ->1, -128 ->0, then 0 ->1
    feed(0, "R2 s1"); check("R2 bit s1", int'(bit_out), 1);
    feed(0, "R2 s2"); check("R2 bit s2", int'(bit_out), 1);
    feed(0, "R2 s3"); check("R2 bit s3", int'(bit_out), 0);
    feed(0, "R2 s4"); check("R2 bit s4", int'(bit_out), 1);
  endtask

  task automatic t_hold();
    logic held;
    do_reset();
    feed(37, "R5 pre");
    feed(-90, "R5 pre");
    held = bit_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); in_vld = 1'b0; in_smp = W'($urandom);
      @(posedge clk); #1;
      check("R5 idle hold", int'(bit_out), int'(held));
    end
    for (int i = 0; i < 8; i++) feed(50 - 20*i, "R5 resume matches model");
  endtask

  task automatic t_density(input int x, input string req);
    int ones = 0;
    int ideal;
    do_reset();
    for (int i = 0; i < 256; i++) begin
      feed(x, "R3 R4 sample");
      ones += int'(bit_out);
    end
    ideal = 256 * (x + FS) / (2 * FS);
    n_chk++;
    if (ones < ideal - 2 || ones > ideal + 2) begin
      n_fail++;
      $display("FAIL %s: actual %0d ones expected %0d", req, ones, ideal);
    end
  endtask

  task automatic t_extremes();
    int ones;
    t_density(-FS, "R7 negative full scale");
    ones = 0;
    for (int i = 0; i < 16; i++) begin feed(-FS, "R7 sat low"); ones += int'(bit_out); end
    check("R7 low tail zeros", ones, 0);
    t_density(FS-1, "R7 positive full scale");
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 5; i++) feed(100, "R8 pre");
    @(negedge clk); rst = 1'b1; in_vld = 1'b1; in_smp = W'(-77);
    @(posedge clk); #1;
    rst = 1'b0; in_vld = 1'b0;
    check("R8 bit after reset", int'(bit_out), 0);
    m_acc = 0; m_bit = 0;
    feed(0, "R8 first sample after reset");
    feed(0, "R8 second sample after reset");
    check("R8 bit second", int'(bit_out), 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_feedback();
    t_hold();
    t_density(-FS/2, "R6 quarter density");
    t_density(0, "R6 half density");
    t_density(FS/2, "R6 three-quarter density");
    t_density(23, "R6 odd level");
    t_extremes();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule